// File: doc/BRIEF.md
# Barrel-Scheduled Multi-Context Processor Core

This core runs ten independent small processors on a single shared execution slot. The complete dynamic state of each processor is one 52-bit word: a 12-bit program address, an 18-bit accumulator, a 12-bit operand holder, a 6-bit opcode latch and a 4-bit step counter. The ten state words move through a shift-register ring. On every clock, the word at the head of the ring passes through the slot and receives one execution step. The result re-enters the ring at the tail. Each context therefore gets exactly one step per rotation of ten cycles, and the decode and arithmetic hardware looks like ten copies.

Every context has its own private word memory of 12-bit words. A read issued while a context is in the slot returns its data at that context's next visit, one full rotation later. An instruction that needs more than one memory word takes several visits to complete. Its progress is carried in the circulating opcode latch, operand holder and step counter. Programs are written into the memories through a simple load port, normally while reset is held.

The slot's context index, program address and accumulator are visible on the ports every cycle. They show the state that is about to be stepped.

Top module: `barrel_core`

## Requirements
- R1: The slot index reads 0 in the first cycle after reset. It then rises by one every clock and wraps from NCTX-1 back to 0.
- R2: Reset clears every context to program address 0 and accumulator 0. A context's first visit after reset only issues the fetch of address 0, so its address and accumulator are the same at its second visit.
- R3: An instruction word is split into opcode bits [11:6] and d bits [5:0]. The one-word opcodes are 0x01 (load d), 0x02 (add d), 0x03 (subtract d) and 0x04 (AND with d). Each uses d zero-extended to 18 bits, wraps modulo 2^18, completes in one visit and advances the address by one.
- R4: Opcode 0x05 shifts the accumulator logically by d[4:0] places and fills with zeros. The shift goes left when d[5] is 0 and right when d[5] is 1. The address advances by one.
- R5: Opcode 0x06 branches when the accumulator is zero, and opcode 0x07 branches when it is nonzero. A taken branch adds the sign-extended d to the address modulo 4096. A branch that is not taken advances the address by one.
- R6: Opcodes 0x08 (load) and 0x09 (add) are two-word immediates. The value is {d, second word}, 18 bits wide. The instruction takes two visits and advances the address by two.
- R7: Opcodes 0x0A (load), 0x0B (add) and 0x0C (subtract) are two-word direct forms. The low MAW bits of the second word address the context's own memory, and the word read there is zero-extended. The instruction takes three visits. The accumulator does not change before the third visit, and the address advances by two.
- R8: Every other opcode leaves the accumulator unchanged and advances the address by one.
- R9: A load-port write stores ld_data at ld_addr in the memory of context ld_ctx only. Each context fetches only from its own memory.
- R10: A context's state changes only while that context is in the slot, by exactly one step per visit. A word read during a visit becomes usable at the same context's next visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Minor-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Program load strobe |
| ld_ctx | input | $clog2(NCTX) | Context whose memory is written |
| ld_addr | input | MAW | Word address of the load |
| ld_data | input | 12 | Word to store |
| slot_ctx | output | $clog2(NCTX) | Context at the slot this cycle |
| slot_pa | output | 12 | Program address of the slot context |
| slot_acc | output | 18 | Accumulator of the slot context |

## Verification
The hardest situation to reach from the ports is a multi-visit instruction whose partial progress sits in the ring while the nine other contexts step through unrelated code. A fault in the circulating opcode latch or step counter only shows up when the rotation brings that context back. Seven contexts run random word streams from a seeded generator, mixing one-word, immediate and direct opcodes with branches. Three contexts run directed programs: arithmetic wraparound, both shift directions, a counted loop ending in a taken branch, and direct addresses whose upper bits must be dropped. A bench model of the instruction set then checks every context's address and accumulator at every visit.

// File: rtl/barrel_core.sv
module barrel_core #(
  parameter int NCTX = 10,
  parameter int MAW  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_en,
  input  logic [$clog2(NCTX)-1:0] ld_ctx,
  input  logic [MAW-1:0]          ld_addr,
  input  logic [11:0]             ld_data,
  output logic [$clog2(NCTX)-1:0] slot_ctx,
  output logic [11:0]             slot_pa,
  output logic [17:0]             slot_acc
);
  localparam int CW = $clog2(NCTX);
  localparam int DEPTH = 1 << MAW;
  localparam logic [CW-1:0] LAST = CW'(NCTX - 1);

  localparam logic [5:0] OP_LDI = 6'h01, OP_ADI = 6'h02, OP_SBI = 6'h03, OP_ANI = 6'h04;
  localparam logic [5:0] OP_SHF = 6'h05, OP_ZJ = 6'h06, OP_NZJ = 6'h07;
  localparam logic [5:0] OP_LDN = 6'h08, OP_ADN = 6'h09;
  localparam logic [5:0] OP_LDM = 6'h0A, OP_ADM = 6'h0B, OP_SBM = 6'h0C;

  typedef struct packed {
    logic [11:0] pa;
    logic [17:0] acc;
    logic [11:0] opnd;
    logic [5:0]  opc;
    logic [3:0]  stp;
  } ctx_t;

  ctx_t ring [NCTX];
  ctx_t cur, nxt;
  logic [11:0] mem [NCTX][DEPTH];
  logic [NCTX-1:0][11:0] rd_q;
  logic [11:0] w;
  logic [5:0]  wop, wd;
  logic [11:0] br_pa;
  logic [MAW-1:0] idx;

  logic [3:0]  slot_step;
  logic [5:0]  slot_opc;
  logic [11:0] slot_word, tail_pa;
  logic [17:0] tail_acc;

  function automatic logic [17:0] alu(input logic [5:0] op, input logic [17:0] a, input logic [17:0] b);
    case (op)
      OP_LDI, OP_LDN, OP_LDM: alu = b;
      OP_ADI, OP_ADN, OP_ADM: alu = a + b;
      OP_SBI, OP_SBM:         alu = a - b;
      OP_ANI:                 alu = a & b;
      default:                alu = a;
    endcase
  endfunction

  assign cur   = ring[0];
  assign w     = rd_q[slot_ctx];
  assign wop   = w[11:6];
  assign wd    = w[5:0];
  assign br_pa = cur.pa + {{6{wd[5]}}, wd};

  always_comb begin
    nxt = cur;
    idx = cur.pa[MAW-1:0];
    case (cur.stp)
      4'd1: begin
        nxt.opc  = wop;
        nxt.opnd = {6'd0, wd};
        nxt.pa   = cur.pa + 12'd1;
        case (wop)
          OP_LDI, OP_ADI, OP_SBI, OP_ANI: nxt.acc = alu(wop, cur.acc, {12'd0, wd});
          OP_SHF: nxt.acc = wd[5] ? (cur.acc >> wd[4:0]) : (cur.acc << wd[4:0]);
          OP_ZJ:  if (cur.acc == '0) nxt.pa = br_pa;
          OP_NZJ: if (cur.acc != '0) nxt.pa = br_pa;
          OP_LDN, OP_ADN, OP_LDM, OP_ADM, OP_SBM: nxt.stp = 4'd2;
          default: ;
        endcase
        idx = nxt.pa[MAW-1:0];
      end
      4'd2: begin
        if (cur.opc == OP_LDN || cur.opc == OP_ADN) begin
          nxt.acc = alu(cur.opc, cur.acc, {cur.opnd[5:0], w});
          nxt.pa  = cur.pa + 12'd1;
          nxt.stp = 4'd1;
          idx     = nxt.pa[MAW-1:0];
        end else begin
          nxt.opnd = w;
          nxt.stp  = 4'd3;
          idx      = w[MAW-1:0];
        end
      end
      4'd3: begin
        nxt.acc = alu(cur.opc, cur.acc, {6'd0, w});
        nxt.pa  = cur.pa + 12'd1;
        nxt.stp = 4'd1;
        idx     = nxt.pa[MAW-1:0];
      end
      default: nxt.stp = 4'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCTX; i++) ring[i] <= '0;
      slot_ctx <= '0;
      rd_q     <= '0;
    end else begin
      for (int i = 0; i < NCTX - 1; i++) ring[i] <= ring[i+1];
      ring[NCTX-1]   <= nxt;
      slot_ctx       <= (slot_ctx == LAST) ? '0 : slot_ctx + 1'b1;
      rd_q[slot_ctx] <= mem[slot_ctx][idx];
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_ctx][ld_addr] <= ld_data;
  end

  assign slot_pa   = cur.pa;
  assign slot_acc  = cur.acc;
  assign slot_step = cur.stp;
  assign slot_opc  = cur.opc;
  assign slot_word = w;
  assign tail_pa   = ring[NCTX-1].pa;
  assign tail_acc  = ring[NCTX-1].acc;
endmodule

// File: rtl/barrel_core_chk.sv
module barrel_core_chk #(
  parameter int NCTX = 10,
  parameter int CW   = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [CW-1:0]         slot_ctx,
  input logic [11:0]           slot_pa,
  input logic [17:0]           slot_acc,
  input logic [3:0]            slot_step,
  input logic [5:0]            slot_opc,
  input logic [11:0]           slot_word,
  input logic [11:0]           tail_pa,
  input logic [17:0]           tail_acc,
  input logic [NCTX-1:0][11:0] rd_q
);
  localparam logic [CW-1:0] LASTC = CW'(NCTX - 1);
  logic was_rst;
  always_ff @(posedge clk) was_rst <= rst;

  // R2
  reset_zero_chk: assert property (@(posedge clk)
    was_rst |-> (slot_ctx == '0 && slot_pa == '0 && slot_acc == '0));

  // R1
  ctx_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((slot_ctx == $past(slot_ctx) + 1'b1) || (slot_ctx == '0 && $past(slot_ctx) == LASTC)));

  // R1
  ctx_range_chk: assert property (@(posedge clk) disable iff (rst) slot_ctx <= LASTC);

  // R2
  prime_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_step == 4'd0) |=> (tail_pa == $past(slot_pa) && tail_acc == $past(slot_acc)));

  // R3
  single_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_step == 4'd1 && slot_word[11:6] >= 6'h01 && slot_word[11:6] <= 6'h05)
      |=> (tail_pa == $past(slot_pa) + 12'd1));

  // R7
  direct_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_step == 4'd2 && slot_opc >= 6'h0A && slot_opc <= 6'h0C)
      |=> (tail_acc == $past(slot_acc) && tail_pa == $past(slot_pa)));

  for (genvar j = 0; j < NCTX; j++) begin : g_priv
    // R10
    word_private_chk: assert property (@(posedge clk) disable iff (rst)
      (slot_ctx != CW'(j)) |=> $stable(rd_q[j]));
  end
endmodule

bind barrel_core barrel_core_chk #(.NCTX(NCTX), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .slot_ctx(slot_ctx), .slot_pa(slot_pa), .slot_acc(slot_acc),
  .slot_step(slot_step), .slot_opc(slot_opc), .slot_word(slot_word),
  .tail_pa(tail_pa), .tail_acc(tail_acc), .rd_q(rd_q)
);

// File: tb/sim_barrel_core.sv
module sim_barrel_core;
  localparam int NCTX = 10, MAW = 6, DEPTH = 64, CW = 4, RUN = 4000;

  logic clk = 1'b0, rst = 1'b1, ld_en = 1'b0;
  logic [CW-1:0] ld_ctx = '0;
  logic [MAW-1:0] ld_addr = '0;
  logic [11:0] ld_data = '0;
  logic [CW-1:0] slot_ctx;
  logic [11:0] slot_pa;
  logic [17:0] slot_acc;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  barrel_core #(.NCTX(NCTX), .MAW(MAW)) u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_ctx(ld_ctx), .ld_addr(ld_addr),
    .ld_data(ld_data), .slot_ctx(slot_ctx), .slot_pa(slot_pa), .slot_acc(slot_acc)
  );

  logic [11:0] bm [NCTX][DEPTH];
  logic [11:0] m_pa [NCTX];
  logic [17:0] m_acc [NCTX];
  int          m_st [NCTX];
  logic [5:0]  m_op [NCTX];
  logic [5:0]  m_d [NCTX];
  logic [11:0] m_adr [NCTX];
  string       m_tag [NCTX];

  function automatic logic [11:0] mk(input logic [5:0] op, input logic [5:0] d);
    return {op, d};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic mstep(input int c);
    logic [11:0] w;
    logic [5:0] d;
    case (m_st[c])
      0: begin m_st[c] = 1; m_tag[c] = "R2"; end
      1: begin
        w = bm[c][m_pa[c][MAW-1:0]];
        d = w[5:0];
        m_op[c] = w[11:6];
        m_d[c] = d;
        if (w[11:6] >= 6'h08 && w[11:6] <= 6'h0C) begin
          m_pa[c] = m_pa[c] + 12'd1;
          m_st[c] = 2;
          m_tag[c] = (w[11:6] <= 6'h09) ? "R6" : "R7";
        end else begin
          m_pa[c] = m_pa[c] + 12'd1;
          m_tag[c] = "R3";
          case (w[11:6])
            6'h01: m_acc[c] = {12'd0, d};
            6'h02: m_acc[c] = m_acc[c] + {12'd0, d};
            6'h03: m_acc[c] = m_acc[c] - {12'd0, d};
            6'h04: m_acc[c] = m_acc[c] & {12'd0, d};
            6'h05: begin
              m_tag[c] = "R4";
              m_acc[c] = d[5] ? (m_acc[c] >> d[4:0]) : (m_acc[c] << d[4:0]);
            end
            6'h06, 6'h07: begin
              m_tag[c] = "R5";
              if ((w[11:6] == 6'h06) == (m_acc[c] == 18'd0))
                m_pa[c] = m_pa[c] - 12'd1 + {{6{d[5]}}, d};
            end
            default: m_tag[c] = "R8";
          endcase
        end
      end
      2: begin
        w = bm[c][m_pa[c][MAW-1:0]];
        if (m_op[c] == 6'h08 || m_op[c] == 6'h09) begin
          m_acc[c] = (m_op[c] == 6'h08) ? {m_d[c], w} : m_acc[c] + {m_d[c], w};
          m_pa[c] = m_pa[c] + 12'd1;
          m_st[c] = 1;
          m_tag[c] = "R6";
        end else begin
          m_adr[c] = w;
          m_st[c] = 3;
          m_tag[c] = "R7";
        end
      end
      default: begin
        w = bm[c][m_adr[c][MAW-1:0]];
        case (m_op[c])
          6'h0A: m_acc[c] = {6'd0, w};
          6'h0B: m_acc[c] = m_acc[c] + {6'd0, w};
          default: m_acc[c] = m_acc[c] - {6'd0, w};
        endcase
        m_pa[c] = m_pa[c] + 12'd1;
        m_st[c] = 1;
        m_tag[c] = "R7";
      end
    endcase
  endtask

  task automatic final_chk(input int c, input logic [11:0] pa, input logic [17:0] acc, input string tag);
    while (slot_ctx != CW'(c)) @(negedge clk);
    chk(tag, "final address", 32'(slot_pa), 32'(pa));
    chk(tag, "final accumulator", 32'(slot_acc), 32'(acc));
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bctx;
    void'($urandom(32'd4711));
    for (int c = 0; c < NCTX; c++) begin
      for (int a = 0; a < DEPTH; a++) bm[c][a] = 12'h000;
      m_pa[c] = '0; m_acc[c] = '0; m_st[c] = 0; m_op[c] = '0; m_d[c] = '0; m_adr[c] = '0;
      m_tag[c] = "R2";
    end
    // R3 R4 R5: arithmetic wrap, both shifts, fall-through and self branch
    bm[0][0] = mk(6'h01, 6'd5);  bm[0][1] = mk(6'h02, 6'd7);  bm[0][2] = mk(6'h03, 6'd20);
    bm[0][3] = mk(6'h04, 6'h3F); bm[0][4] = mk(6'h05, 6'h03); bm[0][5] = mk(6'h05, 6'h22);
    bm[0][6] = mk(6'h06, 6'd2);  bm[0][7] = mk(6'h07, 6'd0);
    // R6 R7: immediates, direct addresses with dropped upper bits
    bm[1][0] = mk(6'h08, 6'h2A); bm[1][1] = 12'h123;
    bm[1][2] = mk(6'h09, 6'h00); bm[1][3] = 12'h001;
    bm[1][4] = mk(6'h0A, 6'h00); bm[1][5] = 12'h041;
    bm[1][6] = mk(6'h0B, 6'h00); bm[1][7] = 12'h014;
    bm[1][8] = mk(6'h0C, 6'h00); bm[1][9] = 12'h015;
    bm[1][10] = mk(6'h07, 6'd0);
    bm[1][20] = 12'h100; bm[1][21] = 12'h023;
    // R5: counted loop
    bm[2][0] = mk(6'h01, 6'd5); bm[2][1] = mk(6'h03, 6'd1);
    bm[2][2] = mk(6'h07, 6'h3F); bm[2][3] = mk(6'h06, 6'd0);
    // R8 R9 R10: random streams in the remaining contexts
    for (int c = 3; c < NCTX; c++)
      for (int a = 0; a < DEPTH; a++)
        bm[c][a] = {6'($urandom % 16), 6'($urandom % 64)};

    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R2", "reset index", 32'(slot_ctx), 32'd0);
    chk("R2", "reset address", 32'(slot_pa), 32'd0);
    chk("R2", "reset accumulator", 32'(slot_acc), 32'd0);

    for (int c = 0; c < NCTX; c++)
      for (int a = 0; a < DEPTH; a++) begin
        ld_en = 1'b1; ld_ctx = CW'(c); ld_addr = MAW'(a); ld_data = bm[c][a];
        @(negedge clk);
      end
    ld_en = 1'b0;
    @(negedge clk);

    rst = 1'b0;
    bctx = 0;
    for (int n = 0; n < RUN; n++) begin
      chk("R1", "slot index", 32'(slot_ctx), 32'(bctx));
      chk(m_tag[bctx], "address (R10)", 32'(slot_pa), 32'(m_pa[bctx]));
      chk(m_tag[bctx], "accumulator (R9)", 32'(slot_acc), 32'(m_acc[bctx]));
      mstep(bctx);
      bctx = (bctx == NCTX - 1) ? 0 : bctx + 1;
      @(negedge clk);
    end

    final_chk(0, 12'd7, 18'h00070, "R4");
    final_chk(1, 12'd10, 18'h00200, "R7");
    final_chk(2, 12'd3, 18'h00000, "R5");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule